// File: doc/BRIEF.md
# Paced Two-Channel DAC Output Sequencer

This block sits between a host-written sample queue and a pair of DAC channel registers. The host pushes samples into an on-chip queue. The queue holds `DEPTH` entries, 4096 by default, and the host can always see how many are waiting. The block then moves those samples to the two channel registers in one of two ways.

In single-value mode the queue, the trigger and the pacing input play no part. A one-cycle write request puts one value straight into the chosen channel register, and that operation is complete in the same cycle.

In continuous mode software first arms the block. A trigger then starts the run, and every pacing tick after the trigger takes two samples from the queue. The older sample of the pair goes to channel-list entry 0 and the next one goes to entry 1, and both registers update together. A run ends in one of three ways:
- by itself, once the data is used up (wrap off);
- on a stop command (wrap on);
- on an underrun, which is sticky.

Writes that arrive while the queue is full are dropped, and a sticky overflow bit records them.

Top module: `dac_pair_sequencer`

## Requirements
- R1: The queue stores up to `DEPTH` samples (default 4096) and releases them in the order they were written. A write is accepted while fewer than `DEPTH` entries are held and `fifo_clr` is low.
- R2: `occupancy` rises by one for each accepted write and falls by two for each conversion, in the cycle after the edge. When a write and a conversion happen in the same cycle, the net change is minus one.
- R3: A conversion loads the older sample of the pair into `ch0_data` and the next sample into `ch1_data`. `ch0_upd` and `ch1_upd` are both high for exactly the one cycle after the conversion edge. The channel registers hold their values at all other times.
- R4: With `mode_single` low, `arm` moves an idle block to armed. Pacing ticks before a `trig` cause no conversion. After `trig`, each `pace_tick` converts one pair.
- R5: After the trigger, a tick that finds fewer than two entries sets `underrun` and ends the run without converting, if wrap is on or if it is the first tick. `underrun` stays set until `err_clr` or `fifo_clr`, and while it is set `arm` is ignored.
- R6: With `wrap_en` low, the run ends right after the conversion that leaves fewer than two entries. No error is raised and later ticks cause no updates.
- R7: With `wrap_en` high, the run continues until `stop`. After `stop` the block is idle in the next cycle, and a `stop` in the same cycle as a tick blocks that conversion.
- R8: With `mode_single` high, `sv_go` writes `sv_data` to channel 0 when `sv_chan` is 0 and to channel 1 when `sv_chan` is 1, pulsing only that channel's strobe. In this mode the queue is never read, and `arm`, `trig`, `pace_tick` and `stop` have no effect. A `stop` in the same cycle as `sv_go` does not cancel the write.
- R9: A write while the queue is full is dropped and `occupancy` stays at `DEPTH`. The write sets `overflow`, which stays set until `err_clr` or `fifo_clr`.
- R10: `busy` goes high in the cycle after a conversion that does not end the run. It goes low in the cycle after the run ends by exhaustion, stop or underrun.
- R11: `fifo_clr` empties the queue, clears `occupancy`, `underrun` and `overflow`, and returns the block to idle. A write in the same cycle as `fifo_clr` is dropped, and the first two samples written after the clear form the next pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_clr | input | 1 | Empty the queue, clear the flags, go idle |
| err_clr | input | 1 | Clear the underrun and overflow flags |
| wr_en | input | 1 | Host write strobe into the queue |
| wr_data | input | DATA_W | Host sample |
| mode_single | input | 1 | 1 = single-value mode, 0 = continuous mode |
| sv_go | input | 1 | Single-value write request |
| sv_chan | input | 1 | Single-value target channel (0 or 1) |
| sv_data | input | DATA_W | Single-value sample |
| arm | input | 1 | Arm a continuous run |
| trig | input | 1 | Start the armed run |
| pace_tick | input | 1 | Pacing clock enable |
| stop | input | 1 | Stop command for continuous mode |
| wrap_en | input | 1 | 1 = run until stop, 0 = run until the data is used up |
| ch0_data | output | DATA_W | Channel-list entry 0 register |
| ch0_upd | output | 1 | Entry 0 update strobe |
| ch1_data | output | DATA_W | Channel-list entry 1 register |
| ch1_upd | output | 1 | Entry 1 update strobe |
| occupancy | output | $clog2(DEPTH)+1 | Number of queued samples |
| busy | output | 1 | Continuous run in progress |
| underrun | output | 1 | Sticky underrun error |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The assertions assume the following about the inputs:
- Every input is held stable for a whole clock cycle.
- Strobes such as `pace_tick`, `stop` and `sv_go` are single-cycle pulses that nobody else gates.
- `DEPTH` is a power of two, so the pointer arithmetic wraps without help.

The stimulus drives every input on the falling edge and releases it one cycle later. It never leaves a strobe high across two edges unless a test asks for it. The tests use a small `DEPTH` so that the full and overflow cases can be reached quickly. Coincident events are set up on purpose: a write together with a tick, `stop` together with `sv_go`, and `arm` while an underrun is pending.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ARMED  = 2'd1,
    SEQ_TRIGD  = 2'd2,
    SEQ_ACTIVE = 2'd3
  } seq_state_t;

  // Queue level after one cycle: plus one per accepted write, minus two per conversion.
  function automatic int occ_after(input int occ, input logic push, input logic pop2);
    return occ + (push ? 1 : 0) - (pop2 ? 2 : 0);
  endfunction

  // A conversion needs a whole even/odd pair in the queue.
  function automatic logic pair_ready(input int occ);
    return occ >= 2;
  endfunction

endpackage

// File: rtl/dac_pair_fifo.sv
module dac_pair_fifo
  import dac_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop2,
  output logic [DATA_W-1:0] rd_even,
  output logic [DATA_W-1:0] rd_odd,
  output logic [$clog2(DEPTH):0] count,
  output logic              full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + AW'(1);
      if (pop2) rp <= rp + AW'(2);
      count <= CW'(occ_after(int'(count), push, pop2));
    end
  end

  assign rd_even = mem[rp];
  assign rd_odd  = mem[rp + AW'(1)];
  assign full    = (int'(count) == DEPTH);

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_clr,
  input  logic          err_clr,
  input  logic          mode_single,
  input  logic          arm,
  input  logic          trig,
  input  logic          pace_tick,
  input  logic          stop,
  input  logic          wrap_en,
  input  logic          wr_en,
  input  logic          fifo_full,
  input  logic [CW-1:0] occupancy,
  output logic          push_ok,
  output logic          conv_ev,
  output logic          ur_ev,
  output logic          end_ev,
  output logic          busy,
  output logic          underrun,
  output logic          overflow
);
  seq_state_t st, st_n;
  logic running, stop_ev, want, have, quiet_end, drained;

  assign push_ok   = wr_en && !fifo_full && !fifo_clr;
  assign running   = (st == SEQ_TRIGD || st == SEQ_ACTIVE) && !mode_single && !fifo_clr;
  assign stop_ev   = stop && !mode_single && st != SEQ_IDLE;
  assign want      = running && pace_tick && !stop_ev;
  assign have      = pair_ready(int'(occupancy));
  assign conv_ev   = want && have;
  assign ur_ev     = want && !have && (wrap_en || st == SEQ_TRIGD);
  assign quiet_end = want && !have && !ur_ev;
  assign drained   = conv_ev && !wrap_en &&
                     !pair_ready(occ_after(int'(occupancy), push_ok, 1'b1));
  assign end_ev    = stop_ev || ur_ev || quiet_end || drained;

  always_comb begin
    st_n = st;
    if (fifo_clr || mode_single || end_ev) st_n = SEQ_IDLE;
    else if (conv_ev)                      st_n = SEQ_ACTIVE;
    else if (st == SEQ_IDLE && arm && !underrun) st_n = SEQ_ARMED;
    else if (st == SEQ_ARMED && trig)      st_n = SEQ_TRIGD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= SEQ_IDLE;
      underrun <= 1'b0;
      overflow <= 1'b0;
    end else begin
      st <= st_n;
      if (fifo_clr || err_clr) underrun <= 1'b0;
      else if (ur_ev)          underrun <= 1'b1;
      if (fifo_clr || err_clr)       overflow <= 1'b0;
      else if (wr_en && fifo_full)   overflow <= 1'b1;
    end
  end

  assign busy = (st == SEQ_ACTIVE);

endmodule

// File: rtl/dac_pair_sequencer.sv
module dac_pair_sequencer
  import dac_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fifo_clr,
  input  logic                   err_clr,
  input  logic                   wr_en,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   mode_single,
  input  logic                   sv_go,
  input  logic                   sv_chan,
  input  logic [DATA_W-1:0]      sv_data,
  input  logic                   arm,
  input  logic                   trig,
  input  logic                   pace_tick,
  input  logic                   stop,
  input  logic                   wrap_en,
  output logic [DATA_W-1:0]      ch0_data,
  output logic                   ch0_upd,
  output logic [DATA_W-1:0]      ch1_data,
  output logic                   ch1_upd,
  output logic [$clog2(DEPTH):0] occupancy,
  output logic                   busy,
  output logic                   underrun,
  output logic                   overflow
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              push_ok, conv_ev, ur_ev, end_ev, fifo_full;
  logic              sv_ev;
  logic [DATA_W-1:0] rd_even, rd_odd;

  assign sv_ev = sv_go && mode_single;

  dac_pair_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push_ok), .wdata(wr_data),
    .pop2(conv_ev), .rd_even(rd_even), .rd_odd(rd_odd), .count(occupancy),
    .full(fifo_full)
  );

  dac_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .err_clr(err_clr),
    .mode_single(mode_single), .arm(arm), .trig(trig), .pace_tick(pace_tick),
    .stop(stop), .wrap_en(wrap_en), .wr_en(wr_en), .fifo_full(fifo_full),
    .occupancy(occupancy), .push_ok(push_ok), .conv_ev(conv_ev), .ur_ev(ur_ev),
    .end_ev(end_ev), .busy(busy), .underrun(underrun), .overflow(overflow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch0_data <= '0;
      ch1_data <= '0;
      ch0_upd  <= 1'b0;
      ch1_upd  <= 1'b0;
    end else begin
      ch0_upd <= conv_ev || (sv_ev && !sv_chan);
      ch1_upd <= conv_ev || (sv_ev && sv_chan);
      if (conv_ev) begin
        ch0_data <= rd_even;
        ch1_data <= rd_odd;
      end else if (sv_ev) begin
        if (sv_chan) ch1_data <= sv_data;
        else         ch0_data <= sv_data;
      end
    end
  end

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker #(
  parameter int CW    = 13,
  parameter int DEPTH = 4096
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_clr,
  input logic          err_clr,
  input logic          wr_en,
  input logic          stop,
  input logic          mode_single,
  input logic          push_ok,
  input logic          conv_ev,
  input logic          ur_ev,
  input logic [CW-1:0] occupancy,
  input logic          underrun,
  input logic          overflow,
  input logic          busy,
  input logic          ch0_upd,
  input logic          ch1_upd
);
  AST_POP_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ev |-> occupancy >= CW'(2)); // R5
  AST_OCC_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_clr && push_ok && !conv_ev) |=> occupancy == $past(occupancy) + CW'(1)); // R2
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occupancy) <= DEPTH); // R9
  AST_OCC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> occupancy == '0); // R11
  AST_PAIR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_ev |=> (ch0_upd && ch1_upd)); // R3
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !err_clr && !fifo_clr) |=> underrun); // R5
  AST_NO_CONV_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !conv_ev); // R5
  AST_SINGLE_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_single |-> !conv_ev); // R8
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !mode_single) |=> !busy); // R7
  AST_OVERFLOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !push_ok && !fifo_clr && !err_clr) |=> overflow); // R9
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(conv_ev)); // R10
  AST_UR_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ur_ev |=> !busy); // R10
endmodule

bind dac_pair_sequencer dac_seq_checker #(.CW(CW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .err_clr(err_clr), .wr_en(wr_en),
  .stop(stop), .mode_single(mode_single), .push_ok(push_ok), .conv_ev(conv_ev),
  .ur_ev(ur_ev), .occupancy(occupancy), .underrun(underrun), .overflow(overflow),
  .busy(busy), .ch0_upd(ch0_upd), .ch1_upd(ch1_upd)
);

// File: tb/dac_pair_sequencer_bench.sv
module dac_pair_sequencer_bench;
  localparam int DW = 16;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic fifo_clr = 0, err_clr = 0, wr_en = 0, mode_single = 0, sv_go = 0, sv_chan = 0;
  logic arm = 0, trig = 0, pace_tick = 0, stop = 0, wrap_en = 0;
  logic [DW-1:0] wr_data = '0, sv_data = '0;
  logic [DW-1:0] ch0_data, ch1_data;
  logic ch0_upd, ch1_upd, busy, underrun, overflow;
  logic [CW-1:0] occupancy;

  always #5 clk = ~clk;

  dac_pair_sequencer #(.DATA_W(DW), .DEPTH(DEPTH)) u_dac_pair_sequencer (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .err_clr(err_clr), .wr_en(wr_en),
    .wr_data(wr_data), .mode_single(mode_single), .sv_go(sv_go), .sv_chan(sv_chan),
    .sv_data(sv_data), .arm(arm), .trig(trig), .pace_tick(pace_tick), .stop(stop),
    .wrap_en(wrap_en), .ch0_data(ch0_data), .ch0_upd(ch0_upd), .ch1_data(ch1_data),
    .ch1_upd(ch1_upd), .occupancy(occupancy), .busy(busy), .underrun(underrun),
    .overflow(overflow)
  );

  typedef struct { bit u0; bit u1; logic [DW-1:0] d0; logic [DW-1:0] d1; string tag; } exp_t;
  exp_t exp_q[$];
  logic [DW-1:0] model_q[$];
  int total = 0, bad = 0;
  bit mon_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Monitor: every strobe must match the oldest expected item.
  always @(negedge clk) begin
    if (mon_on && (ch0_upd || ch1_upd)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected update", {ch1_upd, ch0_upd}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(ch0_upd == e.u0 && ch1_upd == e.u1, {e.tag, " strobes"}, {ch1_upd, ch0_upd}, {e.u1, e.u0});
        if (e.u0) chk(ch0_data == e.d0, {e.tag, " ch0"}, ch0_data, e.d0);
        if (e.u1) chk(ch1_data == e.d1, {e.tag, " ch1"}, ch1_data, e.d1);
      end
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [DW-1:0] v, input bit stored);
    wr_en = 1; wr_data = v; step(); wr_en = 0;
    if (stored) model_q.push_back(v);
  endtask

  task automatic expect_pair(input string tag);
    exp_t e;
    e.u0 = 1; e.u1 = 1; e.tag = tag;
    e.d0 = model_q.pop_front();
    e.d1 = model_q.pop_front();
    exp_q.push_back(e);
  endtask

  task automatic tick(input bit conv, input string tag);
    if (conv) expect_pair(tag);
    pace_tick = 1; step(); pace_tick = 0;
  endtask

  task automatic pulse(input int which);
    case (which)
      0: fifo_clr = 1;
      1: err_clr = 1;
      2: arm = 1;
      3: trig = 1;
      default: stop = 1;
    endcase
    step();
    fifo_clr = 0; err_clr = 0; arm = 0; trig = 0; stop = 0;
  endtask

  task automatic single(input bit ch, input logic [DW-1:0] v, input bit with_stop);
    exp_t e;
    e.u0 = !ch; e.u1 = ch; e.d0 = v; e.d1 = v; e.tag = "R8";
    exp_q.push_back(e);
    sv_go = 1; sv_chan = ch; sv_data = v; stop = with_stop;
    step();
    sv_go = 0; stop = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    mon_on = 1;
    // reset state
    chk(occupancy == 0 && !busy && !underrun && !overflow, "R2 reset", occupancy, 0);
    chk(ch0_data == 0 && ch1_data == 0 && !ch0_upd && !ch1_upd, "R3 reset", ch0_data, 0);

    // single-value mode
    mode_single = 1; step();
    single(1'b1, 16'h1234, 1'b0);
    single(1'b0, 16'h00A5, 1'b1);   // stop alongside does not cancel (R8)
    wr(16'h0B01, 1); wr(16'h0B02, 1);
    pulse(2); pulse(3); tick(0, "R8"); pulse(4);
    step();
    chk(occupancy == 2 && !busy, "R8 queue untouched", occupancy, 2);
    mode_single = 0; step();
    tick(0, "R8"); step();           // arm in single mode did not take
    chk(!busy, "R8 arm ignored", busy, 0);

    // continuous, wrap off
    pulse(0);
    chk(occupancy == 0, "R11 clear", occupancy, 0);
    model_q.delete();
    for (int i = 0; i < 6; i++) wr(16'hC000 + DW'(i), 1);
    chk(occupancy == 6, "R2 writes", occupancy, 6);
    wrap_en = 0;
    pulse(2);
    tick(0, "R4"); tick(0, "R4");
    pulse(3);
    chk(!busy, "R10 not busy before tick", busy, 0);
    tick(1, "R3");
    chk(busy && occupancy == 4, "R10 busy after conversion", {busy, occupancy}, {1'b1, CW'(4)});
    tick(1, "R1");
    tick(1, "R6");
    chk(!busy && !underrun && occupancy == 0, "R6 drained end", {busy, underrun}, 0);
    tick(0, "R6"); step();

    // continuous, wrap on, stop
    for (int i = 0; i < 6; i++) wr(16'hD000 + DW'(i), 1);
    wrap_en = 1;
    pulse(2); pulse(3);
    tick(1, "R7");
    chk(occupancy == 4, "R2 after pop", occupancy, 4);
    expect_pair("R2");
    wr_en = 1; wr_data = 16'hD0AA; pace_tick = 1; step(); wr_en = 0; pace_tick = 0;
    model_q.push_back(16'hD0AA);
    chk(occupancy == 3, "R2 write and pop together", occupancy, 3);
    pace_tick = 1; stop = 1; step(); pace_tick = 0; stop = 0;
    chk(!busy && occupancy == 3, "R7 stop blocks tick", {busy, occupancy}, CW'(3));
    tick(0, "R7");
    chk(!busy, "R7 stays idle", busy, 0);

    // underrun
    pulse(0); model_q.delete();
    wr(16'hE001, 1); wr(16'hE002, 1);
    pulse(2); pulse(3);
    tick(1, "R5");
    chk(busy, "R10 busy wrap on", busy, 1);
    tick(0, "R5");
    chk(underrun && !busy, "R5 underrun set", {underrun, busy}, 2);
    wr(16'hE003, 1); wr(16'hE004, 1);
    pulse(2); pulse(3); tick(0, "R5"); step();
    chk(underrun && occupancy == 2, "R5 sticky, arm ignored", {underrun, occupancy}, {1'b1, CW'(2)});
    pulse(1);
    chk(!underrun, "R5 err_clr", underrun, 0);
    pulse(2); pulse(3); tick(1, "R5");
    pulse(4);
    chk(!busy, "R7 stop", busy, 0);
    wrap_en = 0;
    pulse(2); pulse(3); tick(0, "R5");
    chk(underrun, "R5 first tick empty", underrun, 1);
    pulse(1);

    // overflow
    pulse(0); model_q.delete();
    for (int i = 0; i < DEPTH; i++) wr(16'hF000 + DW'(i), 1);
    chk(int'(occupancy) == DEPTH && !overflow, "R9 full", occupancy, DEPTH);
    wr(16'hDEAD, 0);
    chk(overflow && int'(occupancy) == DEPTH, "R9 dropped", {overflow, occupancy}, {1'b1, CW'(DEPTH)});
    pulse(2); pulse(3); tick(1, "R1");
    chk(overflow, "R9 sticky", overflow, 1);
    pulse(4); pulse(1);
    chk(!overflow, "R9 err_clr", overflow, 0);

    // clear restarts pairing
    pulse(0); model_q.delete();
    wr(16'hA001, 1); wr(16'hA002, 1); wr(16'hA003, 1);
    fifo_clr = 1; wr_en = 1; wr_data = 16'hBAD0; step(); fifo_clr = 0; wr_en = 0;
    model_q.delete();
    chk(occupancy == 0, "R11 clear drops write", occupancy, 0);
    wr(16'h5A01, 1); wr(16'h5A02, 1);
    pulse(2); pulse(3); tick(1, "R11");
    step(); step();

    chk(exp_q.size() == 0, "R3 all expected updates seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule